// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is a single DMA channel that walks a chain of descriptors kept in a descriptor memory. Each descriptor is four 32-bit words at byte offsets 0, 4, 8 and 12 from its address. Offset 0 holds the address of the next descriptor, and a value of zero ends the chain. Offset 4 holds the buffer address. Offset 8 holds the buffer length. Offset 12 holds the mode/status word. Software builds the chain and sets the hardware-owner bit in every mode word it hands over. It then writes the address of the first descriptor to the head register. For each descriptor the engine reads the length and mode words and checks the owner bit. It stands in for the payload transfer by waiting a number of cycles set by the length. It then re-reads the next pointer, writes the mode word back with the owner bit cleared, publishes the finished descriptor's address in the completion register, and raises its interrupt line.

A null next pointer makes the engine mark end-of-queue in that descriptor and go idle. Software resumes the channel by writing a new head. A descriptor linked onto the tail before the engine re-reads the tail's next pointer is still followed. A teardown command aborts the channel. The descriptor in flight is written back with the teardown-complete bit set, and the completion register takes the sentinel 0xFFFFFFFC. Software acknowledges every completion by writing the reported value back to the completion register.

Registers, by byte offset on `reg_addr`:
- 0x00 control: bit 0 is the global enable.
- 0x04 head pointer. A read returns the current descriptor pointer.
- 0x08 completion pointer.
- 0x0C teardown: any write issues the command.
- 0x10 status: bit 0 busy, bit 1 head waiting for enable, bit 2 end-of-queue reached, bit 3 sticky head-write error, bit 4 completion pending.

Top module: `ld_dma_channel`

## Requirements
- R1: After reset the head and completion registers read 0, status reads 0, `irq` is low and no memory access is made.
- R2: A head write while the channel is idle and enabled starts a fetch at that descriptor. The first memory read is at head+8 (length word), followed by head+12 (mode word).
- R3: A fetched descriptor whose mode bit 29 (owner) is clear is not written back and does not change the completion register. The channel goes idle.
- R4: The simulated transfer lasts as many cycles as the low 11 bits of the length word. The time from head write to completion grows by exactly the difference in length.
- R5: Writeback stores the mode word at descriptor+12 with bit 29 cleared. Bits 31 (start of packet), 30 (end of packet) and the low 11 length bits are kept.
- R6: After each descriptor the completion register holds its address and `irq` is high. Writing that same value to the completion register lowers `irq`. Writing any other value does not.
- R7: The engine follows non-zero next pointers, completing every descriptor of a chain in order.
- R8: The descriptor whose next pointer is zero is written back with bit 28 (end of queue) set. The channel goes idle with status bit 2 set, and a later head write restarts it.
- R9: The next pointer is re-read after the transfer, so a descriptor linked onto the tail during its transfer is processed and the old tail gets no end-of-queue bit.
- R10: With control bit 0 low, a head write is stored (status bit 1) but no memory access is made until the enable is set.
- R11: A head write while the channel is busy is ignored and sets sticky status bit 3. Writing 1 to status bit 3 clears it.
- R12: A teardown during a transfer writes the current descriptor back with bit 27 (teardown complete) set and bit 29 clear. The chain is not followed further. The completion register becomes 0xFFFFFFFC, which is acknowledged by writing 0xFFFFFFFC. A teardown while idle sets the sentinel directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Descriptor memory read request |
| mem_wr_en | output | 1 | Descriptor memory write request |
| mem_addr | output | 32 | Descriptor memory byte address |
| mem_wdata | output | 32 | Descriptor memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| irq | output | 1 | Completion pending |

## Verification
The walk is tried with these descriptor patterns:
- A lone descriptor, which shows the end-of-queue marking.
- A three-deep chain, which shows pointer following and that only the tail carries end-of-queue.
- A chain whose second descriptor is not owned, which shows the engine stopping without writeback.
- A tail that gets a successor linked on while in flight, which shows that the next pointer is re-read late.

Two identical descriptors that differ only in length isolate the transfer timing. Head writes under a low enable, and while busy, separate storing from ignoring. A teardown in mid-transfer is set against one issued while idle.

// File: rtl/ld_dma_channel.sv
module ld_dma_channel #(
  parameter int LEN_BITS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        irq
);

  localparam logic [4:0]  OFS_CTRL = 5'h00;
  localparam logic [4:0]  OFS_HEAD = 5'h04;
  localparam logic [4:0]  OFS_COMP = 5'h08;
  localparam logic [4:0]  OFS_TEAR = 5'h0C;
  localparam logic [4:0]  OFS_STAT = 5'h10;
  localparam logic [31:0] SENTINEL = 32'hFFFF_FFFC;
  localparam int B_OWN = 29;
  localparam int B_EOQ = 28;
  localparam int B_TDC = 27;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CAP, S_XFER, S_NRD, S_NCAP, S_WB, S_DONE
  } state_t;

  state_t              st;
  logic                en_q, head_wait, td_req, td_hit, pend, err_q, eoq_q;
  logic [31:0]         cur, nxt, mode_q, cp_q;
  logic [LEN_BITS-1:0] len_q, cnt;
  logic [1:0]          idx;

  wire busy    = (st != S_IDLE);
  wire head_wr = reg_wr && reg_addr == OFS_HEAD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; en_q <= 1'b0; head_wait <= 1'b0; td_req <= 1'b0;
      td_hit <= 1'b0; pend <= 1'b0; err_q <= 1'b0; eoq_q <= 1'b0;
      cur <= '0; nxt <= '0; mode_q <= '0; cp_q <= '0;
      len_q <= '0; cnt <= '0; idx <= 2'd2;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL) en_q <= reg_wdata[0];
      if (reg_wr && reg_addr == OFS_STAT && reg_wdata[3]) err_q <= 1'b0;
      if (reg_wr && reg_addr == OFS_COMP && reg_wdata == cp_q) pend <= 1'b0;
      if (reg_wr && reg_addr == OFS_TEAR) begin
        if (busy) td_req <= 1'b1;
        else begin
          head_wait <= 1'b0;
          cp_q      <= SENTINEL;
          pend      <= 1'b1;
        end
      end
      if (head_wr) begin
        if (busy) err_q <= 1'b1;
        else begin
          cur       <= reg_wdata;
          head_wait <= (reg_wdata != 32'd0);
          eoq_q     <= 1'b0;
        end
      end

      unique case (st)
        S_IDLE: begin
          if (td_req) begin
            td_req <= 1'b0;
            cp_q   <= SENTINEL;
            pend   <= 1'b1;
          end else if (en_q && head_wait && !head_wr) begin
            head_wait <= 1'b0;
            idx       <= 2'd2;
            st        <= S_RD;
          end
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          if (idx == 2'd2) begin
            len_q <= mem_rdata[LEN_BITS-1:0];
            idx   <= 2'd3;
            st    <= S_RD;
          end else begin
            mode_q <= mem_rdata;
            cnt    <= '0;
            st     <= mem_rdata[B_OWN] ? S_XFER : S_IDLE;
          end
        end
        S_XFER: begin
          if (td_req) begin
            td_req <= 1'b0;
            td_hit <= 1'b1;
            st     <= S_WB;
          end else if (cnt == len_q) st <= S_NRD;
          else cnt <= cnt + 1'b1;
        end
        S_NRD:  st <= S_NCAP;
        S_NCAP: begin
          nxt <= mem_rdata;
          st  <= S_WB;
        end
        S_WB:   st <= S_DONE;
        S_DONE: begin
          pend   <= 1'b1;
          td_hit <= 1'b0;
          if (td_hit) begin
            cp_q <= SENTINEL;
            st   <= S_IDLE;
          end else begin
            cp_q <= cur;
            if (nxt == 32'd0) begin
              eoq_q <= 1'b1;
              cur   <= '0;
              st    <= S_IDLE;
            end else begin
              cur <= nxt;
              idx <= 2'd2;
              st  <= S_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_en = (st == S_RD) || (st == S_NRD);
  assign mem_wr_en = (st == S_WB);
  assign mem_addr  = (st == S_NRD) ? cur :
                     (st == S_WB)  ? cur + 32'd12 : cur + (32'(idx) << 2);
  assign mem_wdata = (mode_q & ~(32'd1 << B_OWN))
                   | (td_hit ? (32'd1 << B_TDC) : 32'd0)
                   | (!td_hit && nxt == 32'd0 ? (32'd1 << B_EOQ) : 32'd0);
  assign irq = pend;

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = {31'd0, en_q};
      OFS_HEAD: reg_rdata = cur;
      OFS_COMP: reg_rdata = cp_q;
      OFS_STAT: reg_rdata = {27'd0, pend, err_q, eoq_q, head_wait, busy};
      default:  reg_rdata = 32'd0;
    endcase
  end

  a_r5_wb_clears_owner: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !mem_wdata[B_OWN]);
  a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r12_td_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wdata[B_TDC]) |=> ##1 (cp_q == SENTINEL && pend));
  a_r8_eoq_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_wdata[B_EOQ]) |=> ##1 (st == S_IDLE));
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !$past(err_q)) |-> $past(head_wr && busy));
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !en_q) |=> !mem_rd_en);

endmodule

// File: tb/tb_ld_dma_channel.sv
module tb_ld_dma_channel;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_addr, mem_wdata, mem_rdata = 0;
  logic mem_rd_en, mem_wr_en, irq;
  logic [31:0] mem [64];
  int checks = 0, fails = 0, wb_cnt = 0, rd_cnt = 0;
  logic [31:0] first_rd = 0;
  logic first_seen = 0;

  localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000,
    OWN = 32'h2000_0000, EOQ = 32'h1000_0000, TDC = 32'h0800_0000;
  localparam logic [31:0] SENT = 32'hFFFF_FFFC;

  ld_dma_channel dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[7:2]];
      rd_cnt <= rd_cnt + 1;
      if (!first_seen) begin first_rd <= mem_addr; first_seen <= 1; end
    end
    if (mem_wr_en) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      wb_cnt <= wb_cnt + 1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic mkdesc(int a, logic [31:0] nx, logic [31:0] len, logic [31:0] md);
    mem[a/4] = nx; mem[a/4+1] = 32'h1000 + a; mem[a/4+2] = len; mem[a/4+3] = md;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h10, s);
      if (s[1:0] == 2'b00) return;
    end
  endtask

  task automatic ack();
    logic [31:0] c;
    rd(5'h08, c);
    wr(5'h08, c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h04, v); chk("R1", "head after reset", v, 0);
    rd(5'h08, v); chk("R1", "completion after reset", v, 0);
    rd(5'h10, v); chk("R1", "status after reset", v, 0);
    chk("R1", "irq after reset", {31'd0, irq}, 0);
    chk("R1", "no memory access", rd_cnt + wb_cnt, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    mkdesc(32'h40, 0, 5, SOP | EOP | OWN | 5);
    wr(5'h00, 1);
    wr(5'h04, 32'h40);
    wait_idle();
    chk("R2", "first fetch address", first_rd, 32'h48);
    chk("R5", "mode writeback", mem[16 + 3], SOP | EOP | 5 | EOQ);
    chk("R8", "eoq set on lone descriptor", mem[19] & EOQ, EOQ);
    rd(5'h10, v); chk("R8", "status eoq bit", {31'd0, v[2]}, 1);
    rd(5'h08, v); chk("R6", "completion pointer", v, 32'h40);
    chk("R6", "irq raised", {31'd0, irq}, 1);
    wr(5'h08, 32'h44);
    chk("R6", "irq kept after wrong ack", {31'd0, irq}, 1);
    wr(5'h08, 32'h40);
    chk("R6", "irq cleared by ack", {31'd0, irq}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int w0 = wb_cnt;
    mkdesc(32'h40, 32'h50, 3, SOP | OWN | 3);
    mkdesc(32'h50, 32'h60, 4, OWN | 4);
    mkdesc(32'h60, 0, 2, EOP | OWN | 2);
    wr(5'h04, 32'h40);
    wait_idle();
    chk("R8", "restart after eoq, writebacks", wb_cnt - w0, 3);
    chk("R7", "first of chain", mem[19], SOP | 3);
    chk("R7", "middle of chain", mem[23], 32'd4);
    chk("R7", "tail of chain", mem[27], EOP | EOQ | 2);
    rd(5'h08, v); chk("R7", "completion is tail", v, 32'h60);
    ack();
  endtask

  task automatic t_unowned();
    logic [31:0] v;
    int w0 = wb_cnt;
    mkdesc(32'h40, 32'h50, 2, OWN | 2);
    mkdesc(32'h50, 0, 2, 32'd2);
    wr(5'h04, 32'h40);
    wait_idle();
    chk("R3", "only owned descriptor written", wb_cnt - w0, 1);
    chk("R3", "unowned mode untouched", mem[23], 32'd2);
    rd(5'h08, v); chk("R3", "completion stays at owned one", v, 32'h40);
    rd(5'h10, v); chk("R3", "idle, no eoq", v[2:0], 3'b000);
    ack();
  endtask

  task automatic measure(logic [31:0] len, output int cyc);
    mkdesc(32'h40, 0, len, OWN | len);
    wr(5'h04, 32'h40);
    cyc = 0;
    while (!irq && cyc < 5000) begin @(negedge clk); cyc++; end
    wait_idle();
    ack();
  endtask

  task automatic t_timing();
    int a, b;
    measure(5, a);
    measure(25, b);
    chk("R4", "transfer time difference", b - a, 20);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    int r0, w0;
    wr(5'h00, 0);
    mkdesc(32'h40, 0, 2, OWN | 2);
    r0 = rd_cnt; w0 = wb_cnt;
    wr(5'h04, 32'h40);
    repeat (20) @(negedge clk);
    chk("R10", "no fetch while disabled", rd_cnt - r0, 0);
    rd(5'h10, v); chk("R10", "head waiting bit", {31'd0, v[1]}, 1);
    wr(5'h00, 1);
    wait_idle();
    chk("R10", "processed after enable", wb_cnt - w0, 1);
    ack();
  endtask

  task automatic t_busy_head();
    logic [31:0] v;
    mkdesc(32'h40, 0, 200, OWN | 200);
    mkdesc(32'h50, 0, 2, OWN | 2);
    wr(5'h04, 32'h40);
    repeat (10) @(negedge clk);
    wr(5'h04, 32'h50);
    rd(5'h10, v); chk("R11", "sticky error set", {31'd0, v[3]}, 1);
    wait_idle();
    rd(5'h08, v); chk("R11", "busy head write ignored", v, 32'h40);
    chk("R11", "second descriptor untouched", mem[23], OWN | 2);
    rd(5'h10, v); chk("R11", "error still sticky", {31'd0, v[3]}, 1);
    wr(5'h10, 32'h8);
    rd(5'h10, v); chk("R11", "error cleared", {31'd0, v[3]}, 0);
    ack();
  endtask

  task automatic t_late_chain();
    logic [31:0] v;
    mkdesc(32'h40, 0, 100, OWN | 100);
    mkdesc(32'h50, 0, 3, OWN | 3);
    wr(5'h04, 32'h40);
    repeat (20) @(negedge clk);
    mem[16] = 32'h50;
    wait_idle();
    chk("R9", "old tail without eoq", mem[19], 32'd100);
    chk("R9", "linked descriptor done", mem[23], EOQ | 3);
    rd(5'h08, v); chk("R9", "completion at linked one", v, 32'h50);
    ack();
  endtask

  task automatic t_teardown();
    logic [31:0] v;
    mkdesc(32'h40, 32'h50, 300, SOP | OWN | 300);
    mkdesc(32'h50, 0, 3, OWN | 3);
    wr(5'h04, 32'h40);
    repeat (20) @(negedge clk);
    wr(5'h0C, 1);
    wait_idle();
    chk("R12", "torn-down descriptor mode", mem[19], SOP | TDC | 300);
    chk("R12", "chain not followed", mem[23], OWN | 3);
    rd(5'h08, v); chk("R12", "sentinel completion", v, SENT);
    chk("R12", "irq on teardown", {31'd0, irq}, 1);
    wr(5'h08, SENT);
    chk("R12", "sentinel ack clears irq", {31'd0, irq}, 0);
    wr(5'h08, 32'h0);
    wr(5'h0C, 1);
    rd(5'h08, v); chk("R12", "idle teardown sentinel", v, SENT);
    wr(5'h08, SENT);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_unowned();
    t_timing();
    t_enable();
    t_busy_head();
    t_late_chain();
    t_teardown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule